// File: doc/BRIEF.md
# Soft-Decision LLR Logic Gate Unit

This block lets soft reliability values pass through ordinary Boolean logic. It takes two signed fixed-point log-likelihood ratios and a two-bit opcode. It returns an approximate log-likelihood ratio for NOT, AND, OR or XOR of the bits those ratios describe. The sign convention is that a positive value favours bit 0 and a negative value favours bit 1. The magnitude is the confidence in that decision. Each gate becomes cheap arithmetic on the ratios:

- AND becomes a maximum.
- OR becomes a minimum.
- XOR becomes a sign product applied to the smaller magnitude.
- NOT becomes negation.

The two operands are taken as independent, and no correction term is added.

The block is meant to be replicated inside soft-output decoders built from gate networks. Each operation accepted on a valid-in cycle produces a registered result one clock later, together with a valid-out strobe. Alongside the result come a hard-decision bit and a flag that marks when the most negative code had to be clipped.

Top module: `llr_soft_gate`

## Requirements
- R1: A synchronous active-high reset drives out_valid, llr_y, hard_y and sat_y to zero on the next clock edge.
- R2: out_valid equals in_valid of the previous cycle. llr_y, hard_y and sat_y update only on cycles where in_valid is high, and otherwise keep their values.
- R3: Opcode 2'b00 (NOT) yields the two's-complement negation of llr_a, and llr_b has no effect. An llr_a of -128 yields +127 with sat_y set.
- R4: Opcode 2'b01 (AND) yields the larger of llr_a and llr_b, both compared as signed values.
- R5: Opcode 2'b10 (OR) yields the smaller of llr_a and llr_b, both compared as signed values.
- R6: Opcode 2'b11 (XOR) yields the smaller of the two magnitudes, where the magnitude of -128 is taken as 127. The result is negated exactly when the operand sign bits differ, so a zero operand counts as positive. sat_y is set when either operand is -128.
- R7: hard_y is 1 exactly when llr_y is negative, so a zero result gives hard decision 0.
- R8: sat_y is 0 for AND and OR, and for NOT and XOR whenever no operand involved is -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | Gate select: 00 NOT, 01 AND, 10 OR, 11 XOR |
| llr_a | input | 8 | First LLR operand, two's complement |
| llr_b | input | 8 | Second LLR operand, two's complement (ignored by NOT) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| llr_y | output | 8 | Resulting LLR, two's complement |
| hard_y | output | 1 | Hard decision: 1 when llr_y is negative |
| sat_y | output | 1 | Set when -128 had to be clipped to +127 |

## Verification
The assertions assume a few things about the stimulus:
- Opcodes are always one of the four defined codes, which holds for a two-bit field.
- Operands are only sampled while in_valid is high.
- The reset is held for at least one edge before the first operation.

The stimulus keeps to these conditions. It raises in_valid only with fully driven operands, always asserts reset before the first sweep, and uses deliberate idle cycles with changed operands to show that idle data is never absorbed. The operand sweep covers every value of llr_a against a set of llr_b values that includes -128, -127, -1, 0, 1 and 127. This exercises clipping and the zero-sign rule under every opcode.

// File: rtl/llr_gate_pkg.sv
package llr_gate_pkg;
   typedef enum logic [1:0] {
      GATE_NOT = 2'b00,
      GATE_AND = 2'b01,
      GATE_OR  = 2'b10,
      GATE_XOR = 2'b11
   } gate_op_e;
endpackage

// File: rtl/llr_abs_sat.sv
module llr_abs_sat #(
   parameter int W = 8
) (
   input  logic signed [W-1:0] x,
   output logic signed [W-1:0] mag,
   output logic signed [W-1:0] neg,
   output logic                clipped
);
   localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   always_comb begin
      clipped = (x == MOST_NEG);
      neg     = clipped ? MOST_POS : -x;
      mag     = x[W-1] ? neg : x;
   end
endmodule

// File: rtl/llr_minmax.sv
module llr_minmax #(
   parameter int W = 8
) (
   input  logic signed [W-1:0] p,
   input  logic signed [W-1:0] q,
   output logic signed [W-1:0] lo,
   output logic signed [W-1:0] hi
);
   logic p_less;
   always_comb begin
      p_less = (p < q);
      lo     = p_less ? p : q;
      hi     = p_less ? q : p;
   end
endmodule

// File: rtl/llr_gate_core.sv
module llr_gate_core
   import llr_gate_pkg::*;
#(
   parameter int W = 8
) (
   input  gate_op_e            op,
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] y,
   output logic                hard,
   output logic                sat
);
   logic signed [W-1:0] mag_a, mag_b, neg_a, neg_b;
   logic                clip_a, clip_b;
   logic signed [W-1:0] lo_ab, hi_ab, lo_mag, hi_mag;
   logic                flip;

   llr_abs_sat #(.W(W)) u_abs_a (.x(a), .mag(mag_a), .neg(neg_a), .clipped(clip_a));
   llr_abs_sat #(.W(W)) u_abs_b (.x(b), .mag(mag_b), .neg(neg_b), .clipped(clip_b));
   llr_minmax  #(.W(W)) u_cmp_val (.p(a), .q(b), .lo(lo_ab), .hi(hi_ab));
   llr_minmax  #(.W(W)) u_cmp_mag (.p(mag_a), .q(mag_b), .lo(lo_mag), .hi(hi_mag));

   always_comb begin
      flip = a[W-1] ^ b[W-1];
      y    = '0;
      sat  = 1'b0;
      unique case (op)
         GATE_NOT: begin
            y   = neg_a;
            sat = clip_a;
         end
         GATE_AND: y = hi_ab;
         GATE_OR:  y = lo_ab;
         GATE_XOR: begin
            y   = flip ? -lo_mag : lo_mag;
            sat = clip_a | clip_b;
         end
         default: y = '0;
      endcase
      hard = (y < 0);
   end
endmodule

// File: rtl/llr_soft_gate.sv
module llr_soft_gate
   import llr_gate_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [1:0]   op,
   input  logic [W-1:0] llr_a,
   input  logic [W-1:0] llr_b,
   output logic         out_valid,
   output logic [W-1:0] llr_y,
   output logic         hard_y,
   output logic         sat_y
);
   generate
      if (W < 2) begin : g_bad_width
         $error("llr_soft_gate: W must be at least 2");
      end
   endgenerate

   logic signed [W-1:0] core_y;
   logic                core_hard, core_sat;

   llr_gate_core #(.W(W)) u_core (
      .op   (gate_op_e'(op)),
      .a    ($signed(llr_a)),
      .b    ($signed(llr_b)),
      .y    (core_y),
      .hard (core_hard),
      .sat  (core_sat)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         llr_y     <= '0;
         hard_y    <= 1'b0;
         sat_y     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            llr_y  <= core_y;
            hard_y <= core_hard;
            sat_y  <= core_sat;
         end
      end
   end
endmodule

// File: rtl/llr_soft_gate_chk.sv
module llr_soft_gate_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         in_valid,
   input logic [1:0]   op,
   input logic [W-1:0] llr_a,
   input logic [W-1:0] llr_b,
   input logic         out_valid,
   input logic [W-1:0] llr_y,
   input logic         hard_y,
   input logic         sat_y
);
   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && llr_y == '0 && !sat_y)); // R1
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(llr_y) && $stable(sat_y))); // R2
   AST_AND_MAX: assert property (@(posedge clk) disable iff (rst) (in_valid && op == 2'b01) |=> ($signed(llr_y) >= $signed($past(llr_a)) && $signed(llr_y) >= $signed($past(llr_b)))); // R4
   AST_OR_MIN: assert property (@(posedge clk) disable iff (rst) (in_valid && op == 2'b10) |=> ($signed(llr_y) <= $signed($past(llr_a)) && $signed(llr_y) <= $signed($past(llr_b)))); // R5
   AST_HARD_SIGN: assert property (@(posedge clk) disable iff (rst) out_valid |-> (hard_y == llr_y[W-1])); // R7
   AST_NO_SAT_MINMAX: assert property (@(posedge clk) disable iff (rst) (in_valid && op[1] != op[0]) |=> !sat_y); // R8
endmodule

bind llr_soft_gate llr_soft_gate_chk #(.W(W)) u_chk (.*);

// File: tb/llr_soft_gate_bench.sv
`timescale 1ns/1ps
module llr_soft_gate_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [1:0] op = 2'b00;
   logic [7:0] llr_a = '0, llr_b = '0;
   logic       out_valid, hard_y, sat_y;
   logic [7:0] llr_y;
   int checks = 0, failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   llr_soft_gate #(.W(8)) u_llr_soft_gate (.*);

   function automatic int bval(int i);
      case (i)
         0: return -128; 1: return -127; 2: return -1; 3: return 0;
         4: return 1; 5: return 127; 6: return -126; 7: return 126;
         default: return ((i * 37 + 3) % 256) - 128;
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model(int o, int a, int b, output int y, output int s);
      int ma, mb, m;
      s = 0;
      case (o)
         0: begin y = (a == -128) ? 127 : -a; s = (a == -128); end
         1: y = (a > b) ? a : b;
         2: y = (a < b) ? a : b;
         default: begin
            ma = (a == -128) ? 127 : (a < 0 ? -a : a);
            mb = (b == -128) ? 127 : (b < 0 ? -b : b);
            m  = (ma < mb) ? ma : mb;
            y  = ((a < 0) != (b < 0)) ? -m : m;
            s  = (a == -128) || (b == -128);
         end
      endcase
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int ey, es;
      string tag;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 out_valid", out_valid, 0);
      check("R1 llr_y", llr_y, 0);
      check("R1 sat_y", sat_y, 0);
      check("R7 hard_y at reset", hard_y, 0);
      rst = 1'b0;
      for (int o = 0; o < 4; o++) begin
         case (o) 0: tag = "R3"; 1: tag = "R4"; 2: tag = "R5"; default: tag = "R6"; endcase
         for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 32; bi++) begin
               int av, bv;
               av = ai - 128;
               bv = bval(bi);
               op = 2'(o); llr_a = 8'(av); llr_b = 8'(bv); in_valid = 1'b1;
               @(negedge clk);
               model(o, av, bv, ey, es);
               check({tag, " llr_y"}, int'($signed(llr_y)), ey);
               check("R8 sat_y", sat_y, es);
               check("R7 hard_y", hard_y, (ey < 0));
               check("R2 out_valid", out_valid, 1);
            end
         end
      end
      // R2 idle cycle with changed operands must not update
      op = 2'b00; llr_a = 8'd5; llr_b = 8'd0; in_valid = 1'b1;
      @(negedge clk);
      check("R3 neg of 5", int'($signed(llr_y)), -5);
      in_valid = 1'b0; llr_a = 8'h80; op = 2'b00;
      @(negedge clk);
      check("R2 idle out_valid", out_valid, 0);
      check("R2 idle hold llr_y", int'($signed(llr_y)), -5);
      check("R2 idle hold sat_y", sat_y, 0);
      // R1 mid-run reset
      rst = 1'b1;
      @(negedge clk);
      check("R1 mid reset llr_y", llr_y, 0);
      check("R1 mid reset out_valid", out_valid, 0);
      rst = 1'b0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule